// File: doc/BRIEF.md
# ADC channel sweep sequencer

This block is the digital sequencer for a sixteen-input, 12-bit multiplexed converter. Software programs a control word that holds a 16-bit channel-enable mask, a repeat count, a sweep switch, a channel-tag switch and a trigger-source switch. A trigger can come from a self-clearing manual bit or from an external trigger pin. Once a trigger is accepted, the block asks the converter for one sample at a time on a request/valid sample port. Each result is pushed into a 16-entry result FIFO, which software drains by reading the data register.

In sweep mode, each round converts every enabled channel in ascending index order. In single mode, each round converts only the lowest enabled channel. A repeat-count value of N gives N+1 rounds. Each result word carries the sample in its low 12 bits. When tagging is on, the four bits above the sample hold the channel index; when tagging is off, those bits are zero. Channels 0 to 7 are external inputs and channels 8 to 15 are internal sources. The sequencer treats them all the same way.

Top module: `adc_sweep_ctrl`

## Requirements
- R1: After reset, the control, status and data registers all read 0, and `conv_req` is low.
- R2: The block has four registers, selected by `reg_addr`:
  - Address 0 is control. Bits [15:0] are the enable mask, where bit i enables channel i. Bits [19:16] are the repeat count N. Bit 20 enables sweep. Bit 21 enables tagging. Bit 22 enables the external trigger. Bit 23 is the manual trigger.
  - Address 1 is status. Bits [4:0] are the FIFO entry count. Bit 8 is busy. Bit 9 is overflow.
  - Address 2 is result data.
  - Address 3 is FIFO clear.
- R3: In sweep mode, one trigger converts every enabled channel lowest index first, and repeats that whole pass N+1 times.
- R4: In single mode, one trigger converts the lowest enabled channel N+1 times.
- R5: A result word holds the sample in bits [11:0]. Bits [15:12] hold the channel index when tagging is enabled, and read as zero when it is disabled.
- R6: The FIFO holds 16 words. A result that arrives while the FIFO is full is dropped and sets the overflow bit. The overflow bit stays set until a clear.
- R7: A read of the data address returns the oldest word and removes it from the FIFO. A read while the FIFO is empty returns 0 and leaves the count at 0.
- R8: Writing 1 in bit 0 of the clear address empties the FIFO and clears the overflow bit.
- R9: Busy reads 1 from the cycle after a trigger is accepted until the last result of that trigger is stored.
- R10: Triggers are ignored in three cases:
  - The manual trigger bit never reads back as 1.
  - A trigger that arrives while busy is ignored.
  - A trigger with an all-zero mask is ignored.
- R11: When the external trigger is enabled, a cycle with `ext_trig` high starts an operation and the manual bit is ignored. When it is disabled, `ext_trig` is ignored.
- R12: Each conversion raises `conv_req` for one cycle, with the channel index on `conv_chan`. The sample is then taken on the first later cycle where `conv_valid` is high. `conv_valid` has no effect while no request is outstanding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (pops the FIFO at the data address) |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| ext_trig | input | 1 | External trigger, sampled when enabled |
| conv_req | output | 1 | One-cycle conversion request |
| conv_chan | output | 4 | Channel index for the request |
| conv_valid | input | 1 | Sample valid from the converter |
| conv_data | input | 12 | Sample value |

## Verification
A wrong channel pointer or a wrong round counter shows up in the very next word read from the FIFO. The test converter embeds the requested channel and a running sequence index in every sample, so a skipped, repeated or out-of-order channel changes the word at that exact position. A wrong FIFO pointer or count shows up at the next status or data read. A busy flag that is stuck, or that drops early, shows up on the first poll after a trigger, because that poll returns a count different from the expected number of conversions.

// File: rtl/adc_seq_pkg.sv
// Shared constants for the channel sweep sequencer: register addresses,
// control and status field positions, and the sequencer state type.
package adc_seq_pkg;
    localparam int NUM_CH = 16;
    localparam int CH_W   = 4;

    localparam logic [1:0] ADR_CTRL = 2'd0;
    localparam logic [1:0] ADR_STAT = 2'd1;
    localparam logic [1:0] ADR_DATA = 2'd2;
    localparam logic [1:0] ADR_CLR  = 2'd3;

    localparam int CTL_CNT_LSB = 16;
    localparam int CTL_SWEEP   = 20;
    localparam int CTL_TAG     = 21;
    localparam int CTL_EXT     = 22;
    localparam int CTL_MAN     = 23;

    localparam int STA_BUSY = 8;
    localparam int STA_OVF  = 9;

    typedef enum logic [1:0] {
        SQ_IDLE  = 2'd0,
        SQ_ISSUE = 2'd1,
        SQ_WAIT  = 2'd2
    } seq_state_t;
endpackage

// File: rtl/adc_chan_pick.sv
// Finds the lowest enabled channel whose index is at least `start`.
// Assumes NUM_CH fits in CH_W bits; `start` may equal NUM_CH (no match).
module adc_chan_pick #(
    parameter int NUM_CH = 16,
    parameter int CH_W   = 4
) (
    input  logic [NUM_CH-1:0] mask,
    input  logic [CH_W:0]     start,
    output logic              found,
    output logic [CH_W-1:0]   idx
);
    // Priority scan from the top so the lowest qualifying index wins.
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = NUM_CH - 1; i >= 0; i--) begin
            if (mask[i] && (i >= int'(start))) begin
                found = 1'b1;
                idx   = CH_W'(i);
            end
        end
    end
endmodule

// File: rtl/adc_result_fifo.sv
// Result FIFO with drop-on-full, sticky overflow and a synchronous clear.
// Assumes DEPTH is a power of two. Clear wins over push and pop.
module adc_result_fifo #(
    parameter int DEPTH = 16,
    parameter int W     = 16,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             push,
    input  logic [W-1:0]     din,
    input  logic             pop,
    output logic [W-1:0]     head,
    output logic [CNT_W-1:0] count,
    output logic             ovf
);
    logic [W-1:0]     mem [DEPTH];
    logic [PTR_W-1:0] rd_ptr, wr_ptr;
    logic             empty, full, pop_ok, push_ok;

    // Occupancy decode and accepted-operation qualifiers.
    always_comb begin
        empty   = (count == '0);
        full    = (count == CNT_W'(DEPTH));
        pop_ok  = pop && !empty;
        push_ok = push && (!full || pop_ok);
        head    = empty ? '0 : mem[rd_ptr];
    end

    // Pointer, count and overflow bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            rd_ptr <= '0;
            wr_ptr <= '0;
            count  <= '0;
            ovf    <= 1'b0;
        end else begin
            if (pop_ok)  rd_ptr <= rd_ptr + 1'b1;
            if (push_ok) wr_ptr <= wr_ptr + 1'b1;
            count <= count + CNT_W'(push_ok) - CNT_W'(pop_ok);
            if (push && !push_ok) ovf <= 1'b1;
        end
    end

    // Storage write; contents need no reset.
    always_ff @(posedge clk) begin
        if (push_ok && !clr) mem[wr_ptr] <= din;
    end
endmodule

// File: rtl/adc_seq_fsm.sv
// Conversion sequencer: snapshots the configuration on an accepted trigger,
// issues one request per conversion and builds tagged result words.
// Assumes the converter answers each request with exactly one valid pulse.
module adc_seq_fsm
    import adc_seq_pkg::*;
#(
    parameter int SAMPLE_W = 12,
    localparam int WORD_W = SAMPLE_W + CH_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                trig,
    input  logic [NUM_CH-1:0]   cfg_mask,
    input  logic [3:0]          cfg_cnt,
    input  logic                cfg_sweep,
    input  logic                cfg_tag,
    input  logic                conv_valid,
    input  logic [SAMPLE_W-1:0] conv_data,
    output logic                conv_req,
    output logic [CH_W-1:0]     conv_chan,
    output logic                busy,
    output logic                push,
    output logic [WORD_W-1:0]   push_word,
    output logic [NUM_CH-1:0]   act_mask,
    output logic                act_tag
);
    seq_state_t          state;
    logic [CH_W-1:0]     cur_ch;
    logic [3:0]          round;
    logic [3:0]          snap_cnt;
    logic                snap_sweep;
    logic [NUM_CH-1:0]   pick_mask;
    logic                first_found, next_found;
    logic [CH_W-1:0]     first_idx, next_idx;

    // First-channel search uses the live config when idle, the snapshot otherwise.
    always_comb pick_mask = (state == SQ_IDLE) ? cfg_mask : act_mask;

    adc_chan_pick #(.NUM_CH(NUM_CH), .CH_W(CH_W)) u_first (
        .mask(pick_mask), .start('0), .found(first_found), .idx(first_idx)
    );
    adc_chan_pick #(.NUM_CH(NUM_CH), .CH_W(CH_W)) u_next (
        .mask(act_mask), .start({1'b0, cur_ch} + 1'b1),
        .found(next_found), .idx(next_idx)
    );

    // Port-side decode of the state.
    always_comb begin
        conv_req  = (state == SQ_ISSUE);
        conv_chan = cur_ch;
        busy      = (state != SQ_IDLE);
        push      = (state == SQ_WAIT) && conv_valid;
        push_word = {act_tag ? cur_ch : {CH_W{1'b0}}, conv_data};
    end

    // Sequencing: accept trigger, step channels, count rounds.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= SQ_IDLE;
            cur_ch     <= '0;
            round      <= '0;
            snap_cnt   <= '0;
            snap_sweep <= 1'b0;
            act_mask   <= '0;
            act_tag    <= 1'b0;
        end else begin
            unique case (state)
                SQ_IDLE: begin
                    if (trig && first_found) begin
                        act_mask   <= cfg_mask;
                        act_tag    <= cfg_tag;
                        snap_cnt   <= cfg_cnt;
                        snap_sweep <= cfg_sweep;
                        cur_ch     <= first_idx;
                        round      <= '0;
                        state      <= SQ_ISSUE;
                    end
                end
                SQ_ISSUE: state <= SQ_WAIT;
                SQ_WAIT: begin
                    if (conv_valid) begin
                        if (snap_sweep && next_found) begin
                            cur_ch <= next_idx;
                            state  <= SQ_ISSUE;
                        end else if (round == snap_cnt) begin
                            state <= SQ_IDLE;
                        end else begin
                            round  <= round + 1'b1;
                            cur_ch <= first_idx;
                            state  <= SQ_ISSUE;
                        end
                    end
                end
                default: state <= SQ_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/adc_sweep_ctrl.sv
// Top of the channel sweep sequencer: register decode, trigger selection,
// sequencer and result FIFO. Register reads are combinational; a read strobe
// at the data address pops one entry at the clock edge.
module adc_sweep_ctrl
    import adc_seq_pkg::*;
#(
    parameter int FIFO_DEPTH = 16,
    parameter int SAMPLE_W   = 12,
    localparam int WORD_W = SAMPLE_W + CH_W,
    localparam int CNT_W  = $clog2(FIFO_DEPTH + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                reg_wr,
    input  logic                reg_rd,
    input  logic [1:0]          reg_addr,
    input  logic [31:0]         reg_wdata,
    output logic [31:0]         reg_rdata,
    input  logic                ext_trig,
    output logic                conv_req,
    output logic [CH_W-1:0]     conv_chan,
    input  logic                conv_valid,
    input  logic [SAMPLE_W-1:0] conv_data
);
    logic [NUM_CH-1:0] ctrl_mask, cfg_mask;
    logic [3:0]        ctrl_cnt, cfg_cnt;
    logic              ctrl_sweep, ctrl_tag, ctrl_ext;
    logic              cfg_sweep, cfg_tag;
    logic              ctrl_wr, clr_wr, pop_rd, trig;
    logic              seq_busy, seq_push, act_tag;
    logic [NUM_CH-1:0] act_mask;
    logic [WORD_W-1:0] seq_word, fifo_head;
    logic [CNT_W-1:0]  fifo_cnt;
    logic              fifo_ovf;

    // Strobe decode, write-through config and trigger source selection.
    always_comb begin
        ctrl_wr   = reg_wr && (reg_addr == ADR_CTRL);
        clr_wr    = reg_wr && (reg_addr == ADR_CLR) && reg_wdata[0];
        pop_rd    = reg_rd && (reg_addr == ADR_DATA);
        cfg_mask  = ctrl_wr ? reg_wdata[NUM_CH-1:0] : ctrl_mask;
        cfg_cnt   = ctrl_wr ? reg_wdata[CTL_CNT_LSB +: 4] : ctrl_cnt;
        cfg_sweep = ctrl_wr ? reg_wdata[CTL_SWEEP] : ctrl_sweep;
        cfg_tag   = ctrl_wr ? reg_wdata[CTL_TAG] : ctrl_tag;
        trig      = (ctrl_wr && reg_wdata[CTL_MAN] && !reg_wdata[CTL_EXT])
                  || (ctrl_ext && ext_trig);
    end

    // Control register storage; the manual trigger bit is not stored.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_mask  <= '0;
            ctrl_cnt   <= '0;
            ctrl_sweep <= 1'b0;
            ctrl_tag   <= 1'b0;
            ctrl_ext   <= 1'b0;
        end else if (ctrl_wr) begin
            ctrl_mask  <= reg_wdata[NUM_CH-1:0];
            ctrl_cnt   <= reg_wdata[CTL_CNT_LSB +: 4];
            ctrl_sweep <= reg_wdata[CTL_SWEEP];
            ctrl_tag   <= reg_wdata[CTL_TAG];
            ctrl_ext   <= reg_wdata[CTL_EXT];
        end
    end

    adc_seq_fsm #(.SAMPLE_W(SAMPLE_W)) u_seq (
        .clk(clk), .rst_n(rst_n), .trig(trig),
        .cfg_mask(cfg_mask), .cfg_cnt(cfg_cnt), .cfg_sweep(cfg_sweep), .cfg_tag(cfg_tag),
        .conv_valid(conv_valid), .conv_data(conv_data),
        .conv_req(conv_req), .conv_chan(conv_chan), .busy(seq_busy),
        .push(seq_push), .push_word(seq_word), .act_mask(act_mask), .act_tag(act_tag)
    );

    adc_result_fifo #(.DEPTH(FIFO_DEPTH), .W(WORD_W)) u_fifo (
        .clk(clk), .rst_n(rst_n), .clr(clr_wr),
        .push(seq_push), .din(seq_word), .pop(pop_rd),
        .head(fifo_head), .count(fifo_cnt), .ovf(fifo_ovf)
    );

    // Read data multiplexer.
    always_comb begin
        reg_rdata = '0;
        unique case (reg_addr)
            ADR_CTRL: begin
                reg_rdata[NUM_CH-1:0]        = ctrl_mask;
                reg_rdata[CTL_CNT_LSB +: 4]  = ctrl_cnt;
                reg_rdata[CTL_SWEEP]         = ctrl_sweep;
                reg_rdata[CTL_TAG]           = ctrl_tag;
                reg_rdata[CTL_EXT]           = ctrl_ext;
            end
            ADR_STAT: begin
                reg_rdata[CNT_W-1:0] = fifo_cnt;
                reg_rdata[STA_BUSY]  = seq_busy;
                reg_rdata[STA_OVF]   = fifo_ovf;
            end
            ADR_DATA: reg_rdata[WORD_W-1:0] = fifo_head;
            default:  reg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/adc_sweep_ctrl_chk.sv
// Property checker for the sweep sequencer, bound to the top module.
module adc_sweep_ctrl_chk #(
    parameter int DEPTH = 16,
    parameter int CNT_W = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic             reg_wr,
    input logic             reg_rd,
    input logic [1:0]       reg_addr,
    input logic [31:0]      reg_wdata,
    input logic             conv_req,
    input logic [3:0]       conv_chan,
    input logic             seq_busy,
    input logic             seq_push,
    input logic [15:0]      seq_word,
    input logic [15:0]      act_mask,
    input logic             act_tag,
    input logic [CNT_W-1:0] fifo_cnt,
    input logic             fifo_ovf
);
    logic clr_w, pop_w;
    always_comb begin
        clr_w = reg_wr && (reg_addr == 2'd3) && reg_wdata[0];
        pop_w = reg_rd && (reg_addr == 2'd2);
    end

    assert_cnt_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_cnt <= CNT_W'(DEPTH));
    assert_ovf_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_ovf && !clr_w |=> fifo_ovf);
    assert_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        clr_w |=> (fifo_cnt == '0) && !fifo_ovf);
    assert_empty_pop_R7: assert property (@(posedge clk) disable iff (!rst_n)
        pop_w && (fifo_cnt == '0) && !seq_push |=> fifo_cnt == '0);
    assert_tag_off_R5: assert property (@(posedge clk) disable iff (!rst_n)
        seq_push && !act_tag |-> seq_word[15:12] == 4'd0);
    assert_req_enabled_R12: assert property (@(posedge clk) disable iff (!rst_n)
        conv_req |-> act_mask[conv_chan]);
    assert_req_pulse_R12: assert property (@(posedge clk) disable iff (!rst_n)
        conv_req |=> !conv_req);
    assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !seq_busy |-> !conv_req && !seq_push);
endmodule

bind adc_sweep_ctrl adc_sweep_ctrl_chk #(.DEPTH(FIFO_DEPTH), .CNT_W(CNT_W)) chk_i (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .conv_req(conv_req), .conv_chan(conv_chan),
    .seq_busy(seq_busy), .seq_push(seq_push), .seq_word(seq_word),
    .act_mask(act_mask), .act_tag(act_tag),
    .fifo_cnt(fifo_cnt), .fifo_ovf(fifo_ovf)
);

// File: tb/adc_sweep_ctrl_tb.sv
// Bench for the sweep sequencer: converter model, directed corners and
// seeded random configurations checked against computed expectations.
module adc_sweep_ctrl_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0, reg_rd = 1'b0;
    logic [1:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        ext_trig = 1'b0;
    logic        conv_req;
    logic [3:0]  conv_chan;
    logic        conv_valid = 1'b0;
    logic [11:0] conv_data = '0;

    int total = 0, bad = 0;
    int run_k = 0;
    int exp_ch [256];
    int exp_n;

    always #5 clk = ~clk;

    adc_sweep_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .ext_trig(ext_trig), .conv_req(conv_req), .conv_chan(conv_chan),
        .conv_valid(conv_valid), .conv_data(conv_data)
    );

    // Converter model: random latency, sample = {channel, sequence index}.
    initial begin
        logic       pend = 1'b0;
        int         lat = 0;
        logic [3:0] ch = '0;
        forever begin
            @(negedge clk);
            if (conv_valid) conv_valid = 1'b0;
            if (conv_req) begin
                pend = 1'b1; ch = conv_chan; lat = int'($urandom % 4);
            end else if (pend) begin
                if (lat == 0) begin
                    conv_valid = 1'b1;
                    conv_data  = {ch, 8'(run_k)};
                    run_k++;
                    pend = 1'b0;
                end else lat--;
            end
        end
    end

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(logic [1:0] a, logic [31:0] d);
        @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk); reg_wr = 1'b0;
    endtask

    task automatic rd(logic [1:0] a, output logic [31:0] d);
        @(negedge clk); reg_rd = 1'b1; reg_addr = a;
        #1 d = reg_rdata;
        @(negedge clk); reg_rd = 1'b0;
    endtask

    function automatic logic [31:0] mk_ctrl(logic [15:0] m, logic [3:0] n,
                                            logic sw, logic tg, logic ex, logic mn);
        return {8'd0, mn, ex, tg, sw, n, m};
    endfunction

    function automatic logic [31:0] mk_stat(int cnt, logic busy, logic ovf);
        return {22'd0, ovf, busy, 3'd0, 5'(cnt)};
    endfunction

    // Expected channel order from the requirement text (R3, R4).
    task automatic build_exp(logic [15:0] m, int n, logic sw);
        int low = -1;
        exp_n = 0;
        for (int i = 15; i >= 0; i--) if (m[i]) low = i;
        if (low < 0) return;
        for (int r = 0; r <= n; r++) begin
            if (sw) begin
                for (int i = 0; i < 16; i++) if (m[i]) begin exp_ch[exp_n] = i; exp_n++; end
            end else begin
                exp_ch[exp_n] = low; exp_n++;
            end
        end
    endtask

    task automatic wait_idle();
        logic [31:0] s;
        for (int i = 0; i < 3000; i++) begin
            rd(2'd1, s);
            if (!s[8]) return;
        end
    endtask

    // Drain and compare: word k = {tag ? ch : 0, ch, k}.
    task automatic drain(string req, logic tg);
        logic [31:0] d;
        int keep = (exp_n > 16) ? 16 : exp_n;
        rd(2'd1, d);
        chk({req, " status"}, d, mk_stat(keep, 1'b0, exp_n > 16));
        for (int k = 0; k < keep; k++) begin
            logic [3:0] c = 4'(exp_ch[k]);
            rd(2'd2, d);
            chk({req, " R5 R12 word"}, d, {16'd0, tg ? c : 4'd0, c, 8'(k)});
        end
    endtask

    task automatic run_case(string req, logic [15:0] m, int n, logic sw, logic tg);
        wr(2'd3, 32'd1);
        run_k = 0;
        build_exp(m, n, sw);
        wr(2'd0, mk_ctrl(m, 4'(n), sw, tg, 1'b0, 1'b1));
        wait_idle();
        drain(req, tg);
    endtask

    initial begin
        #(10 * 150000);
        bad++; total++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [31:0] d;
        void'($urandom(32'd20240630));
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        chk("R1 conv_req", {31'd0, conv_req}, 32'd0);
        rd(2'd0, d); chk("R1 R2 ctrl", d, 32'd0);
        rd(2'd1, d); chk("R1 status", d, 32'd0);
        rd(2'd2, d); chk("R1 data", d, 32'd0);

        // R3 sparse sweep, tagged, single pass
        run_case("R3 sparse", 16'h8421, 0, 1'b1, 1'b1);
        // R3 repeated rounds
        run_case("R3 rounds", 16'h0003, 1, 1'b1, 1'b1);
        // R4 single mode repeats lowest channel
        run_case("R4 single", 16'h0050, 2, 1'b0, 1'b1);
        // R5 untagged internal channels
        run_case("R5 untagged", 16'hC100, 0, 1'b1, 1'b0);

        // R7 empty read
        rd(2'd2, d); chk("R7 empty data", d, 32'd0);
        rd(2'd1, d); chk("R7 empty count", d, 32'd0);

        // R6 overflow: 32 conversions into 16 slots
        run_case("R6 overflow", 16'hFFFF, 1, 1'b1, 1'b1);
        run_case("R6 refill", 16'hFFFF, 1, 1'b1, 1'b1);
        // R8 clear
        wr(2'd3, 32'd1);
        rd(2'd1, d); chk("R8 clear", d, 32'd0);

        // R10 self-clearing manual bit and busy-time trigger
        wr(2'd3, 32'd1); run_k = 0; build_exp(16'h000F, 0, 1'b1);
        wr(2'd0, mk_ctrl(16'h000F, 4'd0, 1'b1, 1'b1, 1'b0, 1'b1));
        rd(2'd1, d); chk("R9 busy set", {31'd0, d[8]}, 32'd1);
        wr(2'd0, mk_ctrl(16'h000F, 4'd0, 1'b1, 1'b1, 1'b0, 1'b1));
        rd(2'd0, d); chk("R10 manual reads 0", d, mk_ctrl(16'h000F, 4'd0, 1'b1, 1'b1, 1'b0, 1'b0));
        wait_idle();
        drain("R10 busy trigger", 1'b1);

        // R10 empty mask ignored
        wr(2'd0, mk_ctrl(16'h0000, 4'd0, 1'b1, 1'b1, 1'b0, 1'b1));
        rd(2'd1, d); chk("R10 empty mask", d, 32'd0);

        // R11 external trigger
        wr(2'd0, mk_ctrl(16'h0300, 4'd0, 1'b1, 1'b1, 1'b1, 1'b1));
        repeat (3) @(negedge clk);
        rd(2'd1, d); chk("R11 manual ignored", d, 32'd0);
        run_k = 0; build_exp(16'h0300, 0, 1'b1);
        @(negedge clk); ext_trig = 1'b1;
        @(negedge clk); ext_trig = 1'b0;
        wait_idle();
        drain("R11 ext", 1'b1);
        wr(2'd0, mk_ctrl(16'h0300, 4'd0, 1'b1, 1'b1, 1'b0, 1'b0));
        @(negedge clk); ext_trig = 1'b1;
        @(negedge clk); ext_trig = 1'b0;
        repeat (3) @(negedge clk);
        rd(2'd1, d); chk("R11 ext disabled", d, 32'd0);

        // R12 valid with no request outstanding has no effect
        @(negedge clk); conv_valid = 1'b1; conv_data = 12'hABC;
        repeat (3) @(negedge clk);
        rd(2'd1, d); chk("R12 stray valid", d, 32'd0);

        // Random configurations (R3 R4 R5 R6)
        for (int it = 0; it < 10; it++) begin
            logic [15:0] m = 16'($urandom);
            if (m == 16'd0) m = 16'h0001;
            run_case("R3 R4 random", m, int'($urandom % 3), 1'($urandom), 1'($urandom));
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule